// File: doc/BRIEF.md
# Exception Vector Relocation Unit

This block works out where a 64-bit core jumps when it takes an interrupt. It also works out the machine-state word the core carries into the handler. For each request it receives a class code, the interrupted state word, the partition control fields, the base offset for the class and a fixed prefix. From these it produces the handler address, the new state and an error flag.

A programmable 2-bit relocation mode can move the handler to one of two alternate regions. When it does, address translation stays on in the new state. The unit turns relocation off in four cases: for the system reset class, for the machine-check class, whenever instruction or data translation was off at the moment of the exception, and always under the older exception model. The reserved mode value produces an error flag in place of an address.

An optional output register stage captures the result when a valid strobe arrives. It presents the result one cycle later and holds it until the next request. The block does not save return state, does not arbitrate between exceptions and does not model hypervisor transitions.

Top module: `xvec_reloc`

## Requirements
- R1: With the newer model selected, translation on and a class other than system reset or machine check, the mode value becomes the effective mode. The address is base OR prefix, plus one more OR term that depends on the effective mode: nothing for mode 0, 0x18000 for mode 2, and 0xC000_0000_0000_4000 for mode 3.
- R2: With `model_new` = 0, the effective mode is 0 whatever `pcr_reloc` holds, so the address is base OR prefix.
- R3: Machine check is class code 2. For this class the effective mode is 0, and state bit 12 (machine-check enable) is cleared in the new state.
- R4: System reset is class code 1. For this class the effective mode is 0.
- R5: If state bit 5 (instruction translation) or state bit 4 (data translation) of `cur_state` is 0, the effective mode is 0.
- R6: When the effective mode is 2 or 3, bits 5 and 4 of the new state are both 1.
- R7: An effective mode of 1 sets `sel_err` and drives `vec_addr` to 0. For any other effective mode, `sel_err` is 0.
- R8: When `pcr_ile` is 1, bit 0 (little-endian) of the new state is 1, under both models.
- R9: Every new-state bit not forced by R3, R6 or R8 equals the same bit of `dflt_state`.
- R10: With the output register enabled, `out_valid` is high exactly one cycle after `req_valid`, and the outputs carry that request's result. The outputs hold their value while no request arrives. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_class | input | 4 | Exception class code |
| cur_state | input | 64 | Machine state at the time of the exception |
| model_new | input | 1 | 1 selects the newer exception model |
| pcr_reloc | input | 2 | Relocation mode field of the partition control register |
| pcr_ile | input | 1 | Interrupt-little-endian control bit |
| base_ofs | input | 64 | Base vector offset for the class |
| vec_prefix | input | 64 | Fixed vector prefix |
| dflt_state | input | 64 | Default new-state word |
| out_valid | output | 1 | Result valid |
| vec_addr | output | 64 | Handler entry address |
| new_state | output | 64 | New machine-state word |
| sel_err | output | 1 | Reserved relocation mode was selected |

## Verification
The bench builds the unit with its default parameters: 64-bit address and state, a 4-bit class code, and the output register enabled. Because the class field is only 4 bits wide, the bench can sweep every class code against every relocation mode, all four translation-bit pairs, both models and both little-endian settings. That sweep covers every path that forces the mode off, both alternate offsets and the reserved value, each combined with every other input. Between requests the bench changes inputs while no strobe is present, which shows the registered outputs hold.

// File: rtl/xvec_pkg.sv
package xvec_pkg;

    localparam int CLASS_W = 4;

    typedef logic [CLASS_W-1:0] xcls_t;

    localparam xcls_t XC_SRESET = 4'h1;
    localparam xcls_t XC_MCHK   = 4'h2;

    typedef enum logic [1:0] {
        RL_NONE = 2'd0,
        RL_RSVD = 2'd1,
        RL_LOW  = 2'd2,
        RL_HIGH = 2'd3
    } reloc_e;

endpackage

// File: rtl/xvec_sel.sv
module xvec_sel
    import xvec_pkg::*;
(
    input  logic   model_new,
    input  xcls_t  cls,
    input  logic   cur_ir,
    input  logic   cur_dr,
    input  reloc_e pcr_mode,
    output reloc_e eff_mode
);

    logic class_blocks;
    logic xlate_off;

    always_comb begin
        class_blocks = (cls == XC_SRESET) || (cls == XC_MCHK);
        xlate_off    = !(cur_ir && cur_dr);
        eff_mode     = pcr_mode;
        if (!model_new || class_blocks || xlate_off) begin
            eff_mode = RL_NONE;
        end
    end

endmodule

// File: rtl/xvec_addr.sv
module xvec_addr
    import xvec_pkg::*;
#(
    parameter int                ADDR_W   = 64,
    parameter logic [ADDR_W-1:0] OFS_LOW  = ADDR_W'(64'h0000_0000_0001_8000),
    parameter logic [ADDR_W-1:0] OFS_HIGH = ADDR_W'(64'hC000_0000_0000_4000)
) (
    input  reloc_e            eff_mode,
    input  logic [ADDR_W-1:0] base_ofs,
    input  logic [ADDR_W-1:0] prefix,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);

    logic [ADDR_W-1:0] reloc_term;
    logic [ADDR_W-1:0] plain_addr;

    always_comb begin
        plain_addr = base_ofs | prefix;
        reloc_term = '0;
        err        = 1'b0;
        unique case (eff_mode)
            RL_LOW:  reloc_term = OFS_LOW;
            RL_HIGH: reloc_term = OFS_HIGH;
            RL_RSVD: err        = 1'b1;
            default: reloc_term = '0;
        endcase
        addr = err ? '0 : (plain_addr | reloc_term);
    end

endmodule

// File: rtl/xvec_state.sv
module xvec_state
    import xvec_pkg::*;
#(
    parameter int STATE_W = 64,
    parameter int IR_POS  = 5,
    parameter int DR_POS  = 4,
    parameter int LE_POS  = 0,
    parameter int ME_POS  = 12
) (
    input  reloc_e             eff_mode,
    input  xcls_t              cls,
    input  logic               ile,
    input  logic [STATE_W-1:0] dflt_state,
    output logic [STATE_W-1:0] new_state
);

    always_comb begin
        new_state = dflt_state;
        if (cls == XC_MCHK) begin
            new_state[ME_POS] = 1'b0;
        end
        if (ile) begin
            new_state[LE_POS] = 1'b1;
        end
        if ((eff_mode == RL_LOW) || (eff_mode == RL_HIGH)) begin
            new_state[IR_POS] = 1'b1;
            new_state[DR_POS] = 1'b1;
        end
    end

endmodule

// File: rtl/xvec_reloc.sv
module xvec_reloc
    import xvec_pkg::*;
#(
    parameter int                ADDR_W   = 64,
    parameter int                STATE_W  = 64,
    parameter int                IR_POS   = 5,
    parameter int                DR_POS   = 4,
    parameter int                LE_POS   = 0,
    parameter int                ME_POS   = 12,
    parameter bit                REG_OUT  = 1'b1,
    parameter logic [ADDR_W-1:0] OFS_LOW  = ADDR_W'(64'h0000_0000_0001_8000),
    parameter logic [ADDR_W-1:0] OFS_HIGH = ADDR_W'(64'hC000_0000_0000_4000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [3:0]         req_class,
    input  logic [STATE_W-1:0] cur_state,
    input  logic               model_new,
    input  logic [1:0]         pcr_reloc,
    input  logic               pcr_ile,
    input  logic [ADDR_W-1:0]  base_ofs,
    input  logic [ADDR_W-1:0]  vec_prefix,
    input  logic [STATE_W-1:0] dflt_state,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [STATE_W-1:0] new_state,
    output logic               sel_err
);

    typedef struct packed {
        logic               vld;
        logic               err;
        logic [ADDR_W-1:0]  addr;
        logic [STATE_W-1:0] st;
    } res_t;

    reloc_e             eff_mode;
    logic [ADDR_W-1:0]  addr_c;
    logic [STATE_W-1:0] state_c;
    logic               err_c;
    res_t               res_c;
    res_t               res_o;

    xvec_sel u_sel (
        .model_new (model_new),
        .cls       (xcls_t'(req_class)),
        .cur_ir    (cur_state[IR_POS]),
        .cur_dr    (cur_state[DR_POS]),
        .pcr_mode  (reloc_e'(pcr_reloc)),
        .eff_mode  (eff_mode)
    );

    xvec_addr #(
        .ADDR_W   (ADDR_W),
        .OFS_LOW  (OFS_LOW),
        .OFS_HIGH (OFS_HIGH)
    ) u_addr (
        .eff_mode (eff_mode),
        .base_ofs (base_ofs),
        .prefix   (vec_prefix),
        .addr     (addr_c),
        .err      (err_c)
    );

    xvec_state #(
        .STATE_W (STATE_W),
        .IR_POS  (IR_POS),
        .DR_POS  (DR_POS),
        .LE_POS  (LE_POS),
        .ME_POS  (ME_POS)
    ) u_state (
        .eff_mode   (eff_mode),
        .cls        (xcls_t'(req_class)),
        .ile        (pcr_ile),
        .dflt_state (dflt_state),
        .new_state  (state_c)
    );

    always_comb begin
        res_c.vld  = req_valid;
        res_c.err  = err_c;
        res_c.addr = addr_c;
        res_c.st   = state_c;
    end

    generate
        if (REG_OUT) begin : g_reg
            res_t res_d;
            res_t res_q;

            always_comb begin
                res_d     = res_q;
                res_d.vld = req_valid;
                if (req_valid) begin
                    res_d = res_c;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end

            assign res_o = res_q;

            assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == $past(req_valid));
            assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(req_valid) |-> ($stable(vec_addr) && $stable(new_state) && $stable(sel_err)));
        end else begin : g_comb
            assign res_o = res_c;
        end
    endgenerate

    assign out_valid = res_o.vld;
    assign vec_addr  = res_o.addr;
    assign new_state = res_o.st;
    assign sel_err   = res_o.err;

    assert_old_model_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !model_new) |-> (eff_mode == RL_NONE));
    assert_mchk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == XC_MCHK) |-> (eff_mode == RL_NONE && !state_c[ME_POS]));
    assert_sreset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == XC_SRESET) |-> (eff_mode == RL_NONE));
    assert_xlate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(cur_state[IR_POS] && cur_state[DR_POS])) |-> (eff_mode == RL_NONE));
    assert_xlate_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eff_mode[1]) |-> (state_c[IR_POS] && state_c[DR_POS]));
    assert_rsvd_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((err_c == (eff_mode == RL_RSVD)) && (!err_c || addr_c == '0)));
    assert_le_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pcr_ile) |-> state_c[LE_POS]);

endmodule

// File: tb/xvec_reloc_test.sv
`timescale 1ns/1ps
module xvec_reloc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_class = '0;
    logic [63:0] cur_state = '0;
    logic        model_new = 1'b0;
    logic [1:0]  pcr_reloc = '0;
    logic        pcr_ile = 1'b0;
    logic [63:0] base_ofs = '0;
    logic [63:0] vec_prefix = '0;
    logic [63:0] dflt_state = '0;
    logic        out_valid;
    logic [63:0] vec_addr;
    logic [63:0] new_state;
    logic        sel_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xvec_reloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
        .cur_state(cur_state), .model_new(model_new), .pcr_reloc(pcr_reloc),
        .pcr_ile(pcr_ile), .base_ofs(base_ofs), .vec_prefix(vec_prefix),
        .dflt_state(dflt_state), .out_valid(out_valid), .vec_addr(vec_addr),
        .new_state(new_state), .sel_err(sel_err)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [1:0]  eff;
        logic [63:0] ea, es, ofs, hold_a, hold_s;
        logic        ee;
        string       ta, ts;
        n = 0;
        repeat (3) @(negedge clk);
        chk("R10", "reset valid", {63'd0, out_valid}, 64'd0);
        chk("R10", "reset addr", vec_addr, 64'd0);
        chk("R10", "reset state", new_state, 64'd0);
        chk("R10", "reset err", {63'd0, sel_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 2; m++)
        for (int le = 0; le < 2; le++)
        for (int rl = 0; rl < 4; rl++)
        for (int c = 0; c < 16; c++)
        for (int x = 0; x < 4; x++) begin
            n++;
            model_new  = m[0];
            pcr_ile    = le[0];
            pcr_reloc  = rl[1:0];
            req_class  = c[3:0];
            cur_state  = 64'h5A5A_3C3C_0F0F_F0C3;
            cur_state[5] = x[1];
            cur_state[4] = x[0];
            base_ofs   = 64'h100 * c + 64'h100;
            vec_prefix = n[0] ? 64'h0000_0001_0000_0000 : 64'h0;
            dflt_state = {32'h9000_0000, 16'h0, 16'h1000 | n[15:0]};
            req_valid  = 1'b1;
            // expected values from the requirements
            eff = rl[1:0];
            if (m == 0 || c == 1 || c == 2 || x != 3) eff = 2'd0;
            ee  = (eff == 2'd1);
            ofs = (eff == 2'd2) ? 64'h0000_0000_0001_8000 :
                  (eff == 2'd3) ? 64'hC000_0000_0000_4000 : 64'h0;
            ea  = ee ? 64'h0 : (base_ofs | vec_prefix | ofs);
            es  = dflt_state;
            if (c == 2) es[12] = 1'b0;
            if (le == 1) es[0] = 1'b1;
            if (eff[1]) begin es[5] = 1'b1; es[4] = 1'b1; end
            if (m == 0) ta = "R2";
            else if (c == 2) ta = "R3";
            else if (c == 1) ta = "R4";
            else if (x != 3) ta = "R5";
            else if (rl == 1) ta = "R7";
            else ta = "R1";
            if (eff[1]) ts = "R6";
            else if (le == 1) ts = "R8";
            else if (c == 2) ts = "R3";
            else ts = "R9";
            @(negedge clk);
            req_valid = 1'b0;
            chk("R10", "valid", {63'd0, out_valid}, 64'd1);
            chk(ta, "addr", vec_addr, ea);
            chk(ts, "state", new_state, es);
            chk("R7", "err", {63'd0, sel_err}, {63'd0, ee});
            if (n % 64 == 0) begin
                hold_a = vec_addr;
                hold_s = new_state;
                base_ofs  = ~base_ofs;
                pcr_ile   = ~pcr_ile;
                model_new = 1'b1;
                cur_state = '1;
                pcr_reloc = 2'd3;
                @(negedge clk);
                chk("R10", "idle valid", {63'd0, out_valid}, 64'd0);
                chk("R10", "hold addr", vec_addr, hold_a);
                chk("R10", "hold state", new_state, hold_s);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule